// File: doc/BRIEF.md
# Identifier Acceptance Filter Bank

This block decides whether an incoming frame identifier should be kept by the receive path of a CAN controller. It holds a small bank of filters, four by default. Each filter has a mask word and an identifier word. A separate enable word switches each filter on or off on its own. When at least one filter is switched on, an identifier is accepted if any enabled filter matches it. When no filter is switched on, every identifier is let through.

Software programs the bank through a simple write port. The normal sequence is: clear the enable word, load the mask and identifier words, then set the enable bits again. A filter's mask and identifier cannot be changed while that filter is enabled.

The receive side offers one identifier per cycle with a valid strobe. One cycle later the block returns:
- the accept decision;
- a flag showing the frame passed only because the bank is fully disabled;
- the index of the lowest-numbered enabled filter that matched.

Top module: `afb_filter_bank`

## Requirements
- R1: The enable word is written at configuration address 0. Bit k of the written data enables filter k. Writing 0xF enables all four filters and writing 0 disables them all. A write to the enable word always takes effect, whatever its current value.
- R2: Filter k's mask is written at configuration address 2k+1 and its identifier at address 2k+2. A write to any other address (9 through 15 with four filters) changes nothing.
- R3: An enabled filter matches an incoming identifier when the identifier ANDed with the mask equals the stored identifier ANDed with the same mask. For example, identifier 0x14 fails mask 0xF7 with stored identifier 0x121F and passes mask 0x5431 with stored identifier 0x14.
- R4: When the enable word is non-zero, the frame is accepted exactly when at least one enabled filter matches. Disabled filters never cause acceptance. In that case the bypass flag is 0.
- R5: When the enable word is 0, every offered identifier is accepted with the bypass flag at 1 and a match index of 0.
- R6: When several enabled filters match, the reported index is the lowest-numbered of them.
- R7: A write to the mask or identifier of a filter whose enable bit is set is ignored. The same write takes effect once that filter is disabled.
- R8: The result appears with `res_valid` high in the cycle after `id_valid` was high. In any cycle where `res_valid` is low, `res_accept`, `res_bypass` and `res_idx` are all 0.
- R9: After a synchronous active-low reset, every output is 0, the enable word is 0, and every mask and identifier is 0.
- R10: An identifier offered in the same cycle as a configuration write is judged against the settings that were in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address (0 enable, 2k+1 mask k, 2k+2 identifier k) |
| cfg_wdata | input | 32 | Configuration write data |
| id_valid | input | 1 | Incoming identifier is present |
| id_in | input | 32 | Incoming frame identifier |
| res_valid | output | 1 | Result of the identifier offered the previous cycle |
| res_accept | output | 1 | Frame is to be stored |
| res_bypass | output | 1 | Accepted only because every filter is disabled |
| res_idx | output | 2 | Index of the lowest matching enabled filter |

## Verification
A corrupted mask or identifier register stays invisible until an identifier is offered whose masked bits depend on the bad bit. At that point the accept bit or the index is wrong in the very next cycle. The bench therefore offers identifiers derived from each stored filter value on almost every cycle. A lost write to the enable word shows up in the next result as a wrong bypass flag or a wrong winner. A write that slips past the lock on an enabled filter is exposed by the first probe that relies on that filter's old mask.

// File: rtl/afb_pkg.sv
// Package afb_pkg
// Shared constants and helpers for the acceptance filter bank.
// Assumes the configuration space is word addressed: enable word first,
// then a mask/identifier pair per filter.
package afb_pkg;

    localparam int unsigned EN_ADDR = 0;

    // Configuration address of the mask word of filter k
    function automatic int unsigned mask_addr(input int unsigned k);
        return 2 * k + 1;
    endfunction

    // Configuration address of the identifier word of filter k
    function automatic int unsigned ident_addr(input int unsigned k);
        return 2 * k + 2;
    endfunction

endpackage

// File: rtl/afb_entry.sv
// Module afb_entry
// One filter: holds a mask word and an identifier word, and flags a match
// of the probe identifier when the filter is enabled.
// Assumes the caller decodes addresses; writes are refused while enabled.
module afb_entry #(
    parameter int unsigned ID_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enabled,
    input  logic            wr_mask,
    input  logic            wr_ident,
    input  logic [ID_W-1:0] wdata,
    input  logic [ID_W-1:0] probe,
    output logic            hit
);

    logic [ID_W-1:0] mask_q;
    logic [ID_W-1:0] ident_q;

    // Mask storage, writable only while the filter is disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_mask && !enabled) begin
            mask_q <= wdata;
        end
    end

    // Identifier storage, writable only while the filter is disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ident_q <= '0;
        end else if (wr_ident && !enabled) begin
            ident_q <= wdata;
        end
    end

    // Masked comparison: every bit selected by the mask must agree
    always_comb begin
        hit = enabled && (((probe ^ ident_q) & mask_q) == '0);
    end

endmodule

// File: rtl/afb_prio.sv
// Module afb_prio
// Fixed-priority encoder: reports whether any request is set and the
// index of the lowest-numbered one. Assumes N >= 2.
module afb_prio #(
    parameter int unsigned N = 4,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    // Scan from the top down so the lowest set request is written last
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/afb_filter_bank.sv
// Module afb_filter_bank
// Acceptance filter bank: NUM_FLT mask/identifier filters gated by an
// enable word. A probe identifier gets a registered accept decision,
// a bypass flag (all filters off) and the lowest matching filter index.
// Assumes one probe per cycle; results follow one cycle later.
module afb_filter_bank #(
    parameter int unsigned NUM_FLT = 4,
    parameter int unsigned ID_W    = 32,
    localparam int unsigned AW     = $clog2(2 * NUM_FLT + 1),
    localparam int unsigned IW     = $clog2(NUM_FLT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [ID_W-1:0] cfg_wdata,
    input  logic            id_valid,
    input  logic [ID_W-1:0] id_in,
    output logic            res_valid,
    output logic            res_accept,
    output logic            res_bypass,
    output logic [IW-1:0]   res_idx
);
    import afb_pkg::*;

    logic [NUM_FLT-1:0] en_q;
    logic [NUM_FLT-1:0] hit_vec;
    logic               hit_any;
    logic [IW-1:0]      hit_idx;
    logic               all_off;

    // Enable word register, always writable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (cfg_we && cfg_addr == AW'(EN_ADDR)) begin
            en_q <= cfg_wdata[NUM_FLT-1:0];
        end
    end

    // One filter entry per enable bit, with its own address decode
    for (genvar k = 0; k < NUM_FLT; k++) begin : g_flt
        logic wr_m;
        logic wr_i;
        assign wr_m = cfg_we && (cfg_addr == AW'(mask_addr(k)));
        assign wr_i = cfg_we && (cfg_addr == AW'(ident_addr(k)));

        afb_entry #(.ID_W(ID_W)) entry_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .enabled  (en_q[k]),
            .wr_mask  (wr_m),
            .wr_ident (wr_i),
            .wdata    (cfg_wdata),
            .probe    (id_in),
            .hit      (hit_vec[k])
        );
    end

    afb_prio #(.N(NUM_FLT)) prio_i (
        .req (hit_vec),
        .any (hit_any),
        .idx (hit_idx)
    );

    assign all_off = (en_q == '0);

    // Result register: cleared whenever no identifier was offered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_bypass <= 1'b0;
            res_idx    <= '0;
        end else begin
            res_valid  <= id_valid;
            res_accept <= id_valid && (all_off || hit_any);
            res_bypass <= id_valid && all_off;
            res_idx    <= (id_valid && !all_off) ? hit_idx : '0;
        end
    end

endmodule

// File: rtl/afb_filter_bank_chk.sv
// Module afb_filter_bank_chk
// Temporal checks on the filter bank ports and its enable word.
// Attached to every instance of the top module by the bind below.
module afb_filter_bank_chk #(
    parameter int unsigned NUM_FLT = 4,
    parameter int unsigned ID_W    = 32,
    localparam int unsigned AW     = $clog2(2 * NUM_FLT + 1),
    localparam int unsigned IW     = $clog2(NUM_FLT)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [AW-1:0]      cfg_addr,
    input logic [ID_W-1:0]    cfg_wdata,
    input logic               id_valid,
    input logic               res_valid,
    input logic               res_accept,
    input logic               res_bypass,
    input logic [IW-1:0]      res_idx,
    input logic [NUM_FLT-1:0] en_q
);

    logic [NUM_FLT-1:0] en_seen;

    // Enable word as it stood when the current result was computed
    always_ff @(posedge clk) begin
        if (!rst_n) en_seen <= '0;
        else        en_seen <= en_q;
    end

    AST_EN_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == '0) |=> en_q == $past(cfg_wdata[NUM_FLT-1:0])); // R1
    AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_accept && !res_bypass) |-> en_seen[res_idx]); // R4
    AST_BYPASS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && en_q == '0) |=> (res_bypass && res_accept && res_idx == '0)); // R5
    AST_NO_BYPASS_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && en_q != '0) |=> !res_bypass); // R5
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |=> res_valid); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |=> !res_valid); // R8
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_accept && !res_bypass && res_idx == '0)); // R8

endmodule

bind afb_filter_bank afb_filter_bank_chk #(.NUM_FLT(NUM_FLT), .ID_W(ID_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .id_valid   (id_valid),
    .res_valid  (res_valid),
    .res_accept (res_accept),
    .res_bypass (res_bypass),
    .res_idx    (res_idx),
    .en_q       (en_q)
);

// File: tb/afb_filter_bank_tb_top.sv
// Bench for afb_filter_bank: a behavioural model of the filter settings is
// stepped alongside the design and every output is compared every cycle.
module afb_filter_bank_tb_top;

    localparam int NF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        id_valid = 1'b0;
    logic [31:0] id_in = '0;
    logic        res_valid, res_accept, res_bypass;
    logic [1:0]  res_idx;

    int vectors = 0;
    int misses = 0;
    bit done = 0;

    // Model state
    logic [31:0] m_mask [NF];
    logic [31:0] m_id   [NF];
    logic [3:0]  m_en;
    logic        e_valid, e_accept, e_bypass;
    logic [1:0]  e_idx;
    string       e_tag;

    always #2 clk = ~clk;

    afb_filter_bank dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .id_valid(id_valid), .id_in(id_in),
        .res_valid(res_valid), .res_accept(res_accept),
        .res_bypass(res_bypass), .res_idx(res_idx)
    );

    task automatic compare();
        vectors++;
        if ({res_valid, res_accept, res_bypass, res_idx} !==
            {e_valid, e_accept, e_bypass, e_idx}) begin
            misses++;
            $display("FAIL %s: got v=%b acc=%b byp=%b idx=%0d, expected v=%b acc=%b byp=%b idx=%0d",
                     e_tag, res_valid, res_accept, res_bypass, res_idx,
                     e_valid, e_accept, e_bypass, e_idx);
        end
    endtask

    // One clock: check last result, drive inputs, advance the model
    task automatic step(input logic we, input logic [3:0] a, input logic [31:0] d,
                        input logic v, input logic [31:0] id, input string tag);
        @(negedge clk);
        compare();
        cfg_we = we; cfg_addr = a; cfg_wdata = d; id_valid = v; id_in = id;
        @(posedge clk);
        e_valid = v; e_accept = 0; e_bypass = 0; e_idx = 0; e_tag = tag;
        if (v) begin
            if (m_en == 0) begin
                e_accept = 1; e_bypass = 1;
            end else begin
                for (int k = NF - 1; k >= 0; k--)
                    if (m_en[k] && ((id & m_mask[k]) == (m_id[k] & m_mask[k]))) begin
                        e_accept = 1; e_idx = 2'(k);
                    end
            end
        end
        if (we) begin
            if (a == 0) m_en = d[3:0];
            else if (a <= 4'(2 * NF)) begin
                if (!m_en[(a - 1) / 2]) begin
                    if (a[0]) m_mask[(a - 1) / 2] = d;
                    else      m_id[(a - 1) / 2] = d;
                end
            end
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
        step(1, a, d, 0, 0, tag);
    endtask

    task automatic probe(input logic [31:0] id, input string tag);
        step(0, 0, 0, 1, id, tag);
    endtask

    initial begin
        for (int k = 0; k < NF; k++) begin m_mask[k] = 0; m_id[k] = 0; end
        m_en = 0; e_valid = 0; e_accept = 0; e_bypass = 0; e_idx = 0; e_tag = "R9";
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare();                       // R9 outputs low in reset
        rst_n = 1'b1;

        probe(32'h1234_5678, "R5");      // R5 all filters off after reset
        wr(0, 32'h1, "R1");
        probe(32'hDEAD_BEEF, "R9");      // R9 zero mask matches anything
        wr(0, 32'h0, "R1");
        // program with enable word cleared (R2)
        wr(1, 32'hF7, "R2");   wr(2, 32'h121F, "R2");
        wr(3, 32'h5431, "R2"); wr(4, 32'h14, "R2");
        wr(5, 32'h1234, "R2"); wr(6, 32'h5431, "R2");
        wr(7, 32'hFFF, "R2");  wr(8, 32'h1234, "R2");
        probe(32'h14, "R5");
        wr(0, 32'hF, "R1");
        probe(32'h14, "R3");             // R3 filter 1 wins, filter 0 rejects
        probe(32'h17, "R3");             // R3 filter 0 matches
        probe(32'hABCD_0000, "R4");      // R4 no filter matches
        probe(32'h0000_1234, "R4");
        // R7 writes to enabled filter 1 ignored
        wr(3, 32'h0, "R7");
        probe(32'hABCD_0000, "R7");
        wr(0, 32'hD, "R1");
        probe(32'h14, "R4");             // R4 disabled filter 1 ignored
        wr(3, 32'h0, "R7");              // R7 now takes
        wr(0, 32'hF, "R1");
        probe(32'hABCD_0000, "R7");
        probe(32'h17, "R6");             // R6 filters 0 and 1 both match
        // R2 unused addresses change nothing
        wr(0, 32'h0, "R1");
        for (int a = 9; a < 16; a++) wr(4'(a), 32'h0, "R2");
        wr(0, 32'hF, "R1");
        probe(32'h0000_1234, "R2");
        // R10 write and probe in the same cycle
        step(1, 0, 32'h0, 1, 32'hABCD_0000, "R10");
        step(1, 0, 32'h2, 1, 32'hABCD_0000, "R10");
        step(0, 0, 0, 1, 32'h5431, "R10");
        // Mixed random traffic (R3, R4, R6, R7)
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            int k;
            r = $urandom; k = $urandom_range(0, NF - 1);
            case ($urandom_range(0, 5))
                0: step(1, 0, 32'($urandom_range(0, 15)), 1, m_id[k] ^ (r & ~m_mask[k]), "R6");
                1: step(1, 4'($urandom_range(1, 8)), {16'h0, r[15:0]} & {32{r[20]}}, 0, 0, "R7");
                2: step(0, 0, 0, 1, r, "R4");
                default: step(0, 0, 0, 1, m_id[k] ^ (r & ~m_mask[k]), "R3");
            endcase
        end
        @(negedge clk);
        compare();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            misses++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule